// File: doc/BRIEF.md
# Serial Memory Write Protection Unit

This block sits beside the command engine of a 2048-byte serial memory. For every byte the engine is about to program, it decides whether the target address may be changed. Its answer comes one clock after the request. A permitted write may go on to program the array. A blocked write is still acknowledged on the bus by the engine, but the engine drops the byte and starts no program cycle.

The memory has eight 256-byte blocks, and address bits 10..8 select the block. Only the upper four blocks can be guarded. Two select pins choose which upper block the guarded region starts in. The upper nibble of a configuration byte held at the top address (7FFh) chooses the 16-byte row inside that block. The guarded region runs from that row up to 7FFh. It is active only while the protect-enable pin is high and bit 2 of the configuration byte is set. A separate write-control pin, when high, blocks every address. Its input is expected to be pulled low when left unconnected.

The configuration byte is a register. It loads from the write data whenever a permitted write targets 7FFh. The reset input stands in for the power-on detector and holds the block idle while it is asserted.

Top module: `wpGuardTop`

## Requirements
- R1: While and directly after reset (rstN low, active low), wrPermit and wrBlocked are 0, and the configuration byte is 00h, so no region protection is in force.
- R2: With wrCtl low and protEn low, a request (wrReq high) to any address gives wrPermit=1 and wrBlocked=0 in the cycle after the request.
- R3: With wrCtl high, a request to any address gives wrBlocked=1 and wrPermit=0 in the next cycle, whatever the configuration and pins.
- R4: With protEn high, wrCtl low and configuration bit 2 set, the protected start address is {1, blkSel[1:0], cfg[7:4], 0000b}. A request at or above it is blocked. A request below it is permitted.
- R5: With configuration bit 2 clear, protEn high gives no region protection.
- R6: With protEn low, a set configuration bit 2 gives no region protection.
- R7: Addresses 000h to 3FFh (blocks 0 to 3) are never blocked by region protection, even when the start lies at 400h.
- R8: A permitted request to 7FFh loads wrData into the configuration byte. A blocked request to 7FFh leaves it unchanged.
- R9: A request to 7FFh is judged against the configuration in force before it. Data it loads governs requests from the following request on.
- R10: Without a request both outputs are 0 in the next cycle, and the two outputs are never 1 together.
- R11: Requests made while rstN is low are ignored: outputs stay 0 and the configuration byte does not load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, models power-on reset |
| wrReq | input | 1 | Byte write about to be programmed |
| wrAddr | input | 11 | Target byte address |
| wrData | input | 8 | Byte being written |
| blkSel | input | 2 | Upper block in which protection starts |
| protEn | input | 1 | Protect-enable pin |
| wrCtl | input | 1 | Hardware write-control pin, high blocks all writes |
| wrPermit | output | 1 | Previous request may program the array |
| wrBlocked | output | 1 | Previous request must be discarded after acknowledge |

## Verification
Two functions can fall in the same cycle: a request to 7FFh is judged, and the same request reloads the configuration byte that drives the judgement. The bench provokes this by writing a byte that sets the protect flag to 7FFh while the flag is still clear. It expects that write to be permitted, and the very next request to 7FFh to be blocked. A blocked write to 7FFh that carries different data is then shown to leave the region unchanged, which is judged by probing the addresses on both sides of the start boundary.

// File: rtl/wpPkg.sv
package wpPkg;
  // strobes sent from decision logic to the state-holding datapath
  typedef struct packed {
    logic permit;   // request is allowed to program
    logic block;    // request must be discarded
    logic cfgLoad;  // configuration byte takes the write data
  } wpStrobes_t;
endpackage

// File: rtl/wpData.sv
module wpData import wpPkg::*; #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int COL_W    = 4,
  parameter int FLAG_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        blkSel,
  input  wpStrobes_t        strobes,
  output logic              regionHit,
  output logic              flagSet,
  output logic              topHit,
  output logic              wrPermit,
  output logic              wrBlocked
);
  localparam int ROW_W = ADDR_W - 3 - COL_W;

  logic [DATA_W-1:0] cfgByte;
  logic [ADDR_W-1:0] startAddr;

  assign startAddr = {1'b1, blkSel, cfgByte[DATA_W-1 -: ROW_W], {COL_W{1'b0}}};
  assign regionHit = (wrAddr >= startAddr);
  assign flagSet   = cfgByte[FLAG_BIT];
  assign topHit    = &wrAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgByte   <= '0;
      wrPermit  <= 1'b0;
      wrBlocked <= 1'b0;
    end else begin
      if (strobes.cfgLoad) cfgByte <= wrData;
      wrPermit  <= strobes.permit;
      wrBlocked <= strobes.block;
    end
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(wrPermit && wrBlocked));

  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.cfgLoad |=> $stable(cfgByte));

  a_r8_load_needs_permit: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cfgLoad |=> wrPermit);
endmodule

// File: rtl/wpCtrl.sv
module wpCtrl import wpPkg::*; (
  input  logic       wrReq,
  input  logic       protEn,
  input  logic       wrCtl,
  input  logic       regionHit,
  input  logic       flagSet,
  input  logic       topHit,
  output wpStrobes_t strobes
);
  logic guarded;

  // write control overrides everything; region needs pin and flag together
  assign guarded = wrCtl || (protEn && flagSet && regionHit);

  always_comb begin
    strobes.permit  = wrReq && !guarded;
    strobes.block   = wrReq && guarded;
    strobes.cfgLoad = wrReq && !guarded && topHit;
  end

  always_comb begin
    a_r10_idle: assert (wrReq || (!strobes.permit && !strobes.block));
    a_r3_wc_blocks: assert (!(wrReq && wrCtl) || (strobes.block && !strobes.cfgLoad));
    a_r5_noflag_open: assert (!(wrReq && !wrCtl && !flagSet) || strobes.permit);
  end
endmodule

// File: rtl/wpGuardTop.sv
module wpGuardTop import wpPkg::*; #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int COL_W    = 4,
  parameter int FLAG_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        blkSel,
  input  logic              protEn,
  input  logic              wrCtl,
  output logic              wrPermit,
  output logic              wrBlocked
);
  wpStrobes_t strobes;
  logic regionHit, flagSet, topHit;

  wpCtrl ctrl_i (
    .wrReq(wrReq), .protEn(protEn), .wrCtl(wrCtl),
    .regionHit(regionHit), .flagSet(flagSet), .topHit(topHit),
    .strobes(strobes)
  );

  wpData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .FLAG_BIT(FLAG_BIT)) data_i (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData), .blkSel(blkSel),
    .strobes(strobes), .regionHit(regionHit), .flagSet(flagSet), .topHit(topHit),
    .wrPermit(wrPermit), .wrBlocked(wrBlocked)
  );
endmodule

// File: tb/wpGuardTop_tb.sv
module wpGuardTop_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrReq = 1'b0;
  logic [10:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] blkSel = '0;
  logic protEn = 1'b0;
  logic wrCtl = 1'b0;
  logic wrPermit, wrBlocked;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wpGuardTop dut_i (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .blkSel(blkSel), .protEn(protEn), .wrCtl(wrCtl),
    .wrPermit(wrPermit), .wrBlocked(wrBlocked)
  );

  task automatic check(string req, logic [1:0] got, logic [1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: {permit,blocked} actual %b expected %b", req, got, exp);
    end
  endtask

  // one request, then look at the outputs one edge later
  task automatic req(logic [10:0] a, logic [7:0] d, string r, logic [1:0] exp);
    @(negedge clk);
    wrReq = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrReq = 1'b0;
    check(r, {wrPermit, wrBlocked}, exp);
  endtask

  localparam logic [1:0] OK = 2'b10, BLK = 2'b01, IDLE = 2'b00;

  task automatic t_reset();
    check("R1 reset", {wrPermit, wrBlocked}, IDLE);
    // request during reset with flag-setting data to top
    wrReq = 1'b1; wrAddr = 11'h7FF; wrData = 8'h04; protEn = 1'b1;
    @(negedge clk);
    check("R11 req in reset", {wrPermit, wrBlocked}, IDLE);
    wrReq = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {wrPermit, wrBlocked}, IDLE);
    req(11'h7FE, 8'h00, "R11 cfg not loaded in reset", OK);
    protEn = 1'b0;
  endtask

  task automatic t_open();
    req(11'h000, 8'h11, "R2 open low", OK);
    req(11'h5A5, 8'h22, "R2 open mid", OK);
    req(11'h7FF, 8'h00, "R2 open top", OK);
    @(negedge clk);
    check("R10 idle", {wrPermit, wrBlocked}, IDLE);
  endtask

  task automatic t_wc();
    wrCtl = 1'b1;
    req(11'h000, 8'h00, "R3 wc low addr", BLK);
    req(11'h3FF, 8'h00, "R3 wc block3", BLK);
    req(11'h7FF, 8'h84, "R3 wc top", BLK);
    wrCtl = 1'b0;
    protEn = 1'b1;
    req(11'h7FF, 8'h00, "R8 wc-blocked top did not load", OK);
    protEn = 1'b0;
  endtask

  task automatic t_region();
    blkSel = 2'b01;
    protEn = 1'b1;
    // flag clear: no protection
    req(11'h7FE, 8'h00, "R5 flag clear", OK);
    // same cycle: judged on old cfg, loads new one (start 580h)
    req(11'h7FF, 8'h84, "R9 load judged old cfg", OK);
    req(11'h7FF, 8'h00, "R9 new cfg governs", BLK);
    req(11'h57F, 8'h00, "R4 below start", OK);
    req(11'h580, 8'h00, "R4 at start", BLK);
    req(11'h6C3, 8'h00, "R4 inside", BLK);
    req(11'h100, 8'h00, "R7 lower block", OK);
    // blocked top write above must not have changed cfg
    req(11'h580, 8'h00, "R8 blocked top kept cfg", BLK);
    protEn = 1'b0;
    req(11'h580, 8'h00, "R6 protEn low", OK);
  endtask

  task automatic t_sel();
    // protEn low: load start 7F0h (row F, block 7)
    blkSel = 2'b11;
    req(11'h7FF, 8'hF4, "R8 load top", OK);
    protEn = 1'b1;
    req(11'h7EF, 8'h00, "R4 sel3 below", OK);
    req(11'h7F0, 8'h00, "R4 sel3 at start", BLK);
    // row 0, block 4: start 400h
    blkSel = 2'b00;
    protEn = 1'b0;
    req(11'h7FF, 8'h04, "R8 load row0", OK);
    protEn = 1'b1;
    req(11'h3FF, 8'h00, "R7 3FF never guarded", OK);
    req(11'h400, 8'h00, "R4 start 400", BLK);
    blkSel = 2'b10;
    req(11'h5FF, 8'h00, "R4 sel2 below", OK);
    req(11'h600, 8'h00, "R4 sel2 at start", BLK);
    protEn = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_open();
        t_wc();
        t_region();
        t_sel();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          nChecks++;
          nFails++;
          $display("FAIL watchdog: actual hung expected done");
        end
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule